// File: doc/BRIEF.md
# Criticality-Ordered Eight-Way Selector

This block picks one bit out of a data vector. In its main mode a binary select code chooses the input, just as a plain indexed multiplexer would. Internally, though, the code is first decoded into one match term per input. Those terms then feed a priority chain whose head is a single timing-critical input, so that input sees the shortest path to the output. The other inputs follow the head in ascending index order. Each one is gated by the inverse of every match term above it. Because exactly one match term is ever active, the result is the same as a flat multiplexer for every code.

A second mode takes one select line per input in place of the code and acts as a generic priority selector. The lowest-numbered asserted line wins. When no line is asserted the output is driven to 0, so that the result is always defined.

The input count and the index of the critical input are parameters. The block is purely combinational.

Top module: `crit_prio_sel`

## Requirements
- R1: With `mode_i` = 0 (code mode), `y_o` equals `data_i[sel_code_i]` for every code value and every data pattern.
- R2: In code mode, when `sel_code_i` equals the critical index (default 5), `y_o` follows that input alone, whatever the other data bits hold.
- R3: In code mode, `sel_lines_i` has no effect on `y_o`.
- R4: With `mode_i` = 1 (line mode), when exactly one bit i of `sel_lines_i` is 1, `y_o` equals `data_i[i]`.
- R5: In line mode, when several bits of `sel_lines_i` are 1, `y_o` equals `data_i` at the lowest-numbered set bit.
- R6: In line mode, when `sel_lines_i` is all zeros, `y_o` is 0 for any data.
- R7: In line mode, `sel_code_i` has no effect on `y_o`.
- R8: Inside each chain, at most one input is granted at a time. A grant is present whenever any request is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 1 | 0 = binary code select, 1 = one line per input, lowest index wins |
| data_i | input | N_IN | Data bits, one per input |
| sel_code_i | input | $clog2(N_IN) | Binary select code used in code mode |
| sel_lines_i | input | N_IN | Per-input select lines used in line mode |
| y_o | output | 1 | Selected data bit |

## Verification
Code mode is checked exhaustively: every code is tried against every data pattern. A chain that dropped an inhibit term, or that mis-placed the critical input, would then return a neighbour's bit for at least one pattern. In line mode the bench tries all line patterns. A selector that let the highest set line win, or that OR-ed the chosen inputs together, would be caught on multi-bit patterns. A selector that left the output undriven or stuck at a data bit would be caught on the all-zero pattern. Both ignore requirements are checked by toggling the unused select input while watching `y_o` stay unchanged.

// File: rtl/crit_prio_sel_pkg.sv
package crit_prio_sel_pkg;

   typedef enum logic {
      SEL_CODE  = 1'b0,
      SEL_LINES = 1'b1
   } sel_mode_e;

   // Input index evaluated at chain position pos: head first, then ascending
   // order with the head skipped.
   function automatic int chain_index(input int pos, input int head);
      int idx;
      if (pos == 0) begin
         idx = head;
      end else if ((pos - 1) >= head) begin
         idx = pos;
      end else begin
         idx = pos - 1;
      end
      return idx;
   endfunction

   function automatic int code_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/crit_code_decode.sv
module crit_code_decode #(
   parameter int N_IN = 8,
   parameter int CW   = crit_prio_sel_pkg::code_width(N_IN)
) (
   input  logic [CW-1:0]   code_i,
   output logic [N_IN-1:0] match_o
);

   for (genvar i = 0; i < N_IN; i++) begin : g_match
      assign match_o[i] = (code_i == CW'(i));
   end

   // R8 support: decoded match terms never overlap
   always_comb begin
      a_r8_match_onehot0 : assert ($onehot0(match_o))
         else $error("decoder produced overlapping match terms");
   end

endmodule

// File: rtl/crit_prio_chain.sv
module crit_prio_chain #(
   parameter int N_IN = 8,
   parameter int HEAD = 0
) (
   input  logic [N_IN-1:0] req_i,
   input  logic [N_IN-1:0] data_i,
   output logic [N_IN-1:0] grant_o,
   output logic            y_o
);
   import crit_prio_sel_pkg::*;

   if (HEAD < 0 || HEAD >= N_IN) begin : g_bad_head
      $error("HEAD must index an existing input");
   end

   // taken[k] is high when any input ahead of chain position k is requested
   logic [N_IN:0] taken;
   assign taken[0] = 1'b0;

   for (genvar k = 0; k < N_IN; k++) begin : g_pos
      localparam int IDX = chain_index(k, HEAD);
      assign grant_o[IDX] = req_i[IDX] & ~taken[k];
      assign taken[k+1]   = taken[k] | req_i[IDX];
   end

   assign y_o = |(grant_o & data_i);

   always_comb begin
      a_r8_grant_onehot0 : assert ($onehot0(grant_o))
         else $error("chain granted more than one input");
      a_r8_grant_when_req : assert ((req_i == '0) || (grant_o != '0))
         else $error("request present but nothing granted");
   end

endmodule

// File: rtl/crit_prio_sel.sv
module crit_prio_sel #(
   parameter int N_IN     = 8,
   parameter int CRIT_IDX = 5,
   localparam int CW      = crit_prio_sel_pkg::code_width(N_IN)
) (
   input  logic            mode_i,
   input  logic [N_IN-1:0] data_i,
   input  logic [CW-1:0]   sel_code_i,
   input  logic [N_IN-1:0] sel_lines_i,
   output logic            y_o
);
   import crit_prio_sel_pkg::*;

   if (N_IN < 2) begin : g_bad_n
      $error("N_IN must be at least 2");
   end
   if (CRIT_IDX < 0 || CRIT_IDX >= N_IN) begin : g_bad_crit
      $error("CRIT_IDX out of range");
   end

   logic [N_IN-1:0] code_match;
   logic [N_IN-1:0] code_grant;
   logic [N_IN-1:0] line_grant;
   logic            y_code;
   logic            y_line;

   crit_code_decode #(.N_IN(N_IN), .CW(CW)) u_decode (
      .code_i  (sel_code_i),
      .match_o (code_match)
   );

   // code mode: critical input at the head of the chain
   crit_prio_chain #(.N_IN(N_IN), .HEAD(CRIT_IDX)) u_code_chain (
      .req_i   (code_match),
      .data_i  (data_i),
      .grant_o (code_grant),
      .y_o     (y_code)
   );

   // line mode: plain ascending priority, input 0 first
   crit_prio_chain #(.N_IN(N_IN), .HEAD(0)) u_line_chain (
      .req_i   (sel_lines_i),
      .data_i  (data_i),
      .grant_o (line_grant),
      .y_o     (y_line)
   );

   assign y_o = (sel_mode_e'(mode_i) == SEL_LINES) ? y_line : y_code;

   // reference for the line mode: lowest set line, computed by a scan
   logic ref_line;
   always_comb begin
      ref_line = 1'b0;
      for (int i = N_IN - 1; i >= 0; i--) begin
         if (sel_lines_i[i]) ref_line = data_i[i];
      end
   end

   always_comb begin
      if (mode_i == 1'b0 && int'(sel_code_i) < N_IN) begin
         a_r1_code_equals_index : assert (y_o == data_i[sel_code_i])
            else $error("code mode differs from indexed select");
      end
      if (mode_i == 1'b1) begin
         a_r5_lowest_line_wins : assert (y_o == ref_line)
            else $error("line mode did not pick lowest set line");
      end
      if (mode_i == 1'b1 && sel_lines_i == '0) begin
         a_r6_idle_zero : assert (y_o == 1'b0)
            else $error("line mode idle output not zero");
      end
   end

endmodule

// File: tb/crit_prio_sel_tb.sv
module crit_prio_sel_tb;

   localparam int N  = 8;
   localparam int CW = 3;
   localparam int CRIT = 5;

   logic          clk = 1'b0;
   logic          mode;
   logic [N-1:0]  data;
   logic [CW-1:0] code;
   logic [N-1:0]  lines;
   logic          y;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   crit_prio_sel #(.N_IN(N), .CRIT_IDX(CRIT)) u_dut (
      .mode_i      (mode),
      .data_i      (data),
      .sel_code_i  (code),
      .sel_lines_i (lines),
      .y_o         (y)
   );

   task automatic check(input string req, input logic exp);
      @(negedge clk);
      n_chk++;
      if (y !== exp) begin
         n_fail++;
         $display("FAIL %s: mode=%0b code=%0d lines=%b data=%b y=%b expected %b",
                  req, mode, code, lines, data, y, exp);
      end
   endtask

   function automatic logic lowest(input logic [N-1:0] l, input logic [N-1:0] d);
      for (int i = 0; i < N; i++) if (l[i]) return d[i];
      return 1'b0;
   endfunction

   task automatic t_idle;
      mode = 1'b1; lines = '0; code = '0; data = '1;
      check("R6 idle", 1'b0);
   endtask

   task automatic t_code_exhaustive;
      mode = 1'b0; lines = '0;
      for (int c = 0; c < N; c++) begin
         for (int d = 0; d < (1 << N); d++) begin
            code = CW'(c); data = N'(d);
            check("R1", data[c]);
         end
      end
   endtask

   task automatic t_code_critical;
      mode = 1'b0; code = CW'(CRIT); lines = '0;
      data = ~(N'(1) << CRIT);
      check("R2 crit low, rest high", 1'b0);
      data = N'(1) << CRIT;
      check("R2 crit high, rest low", 1'b1);
   endtask

   task automatic t_code_ignores_lines;
      mode = 1'b0; data = 8'b1010_0110;
      for (int c = 0; c < N; c++) begin
         code = CW'(c);
         lines = '0;          check("R3 lines zero", data[c]);
         lines = '1;          check("R3 lines all", data[c]);
         lines = N'(1) << ((c + 1) % N); check("R3 lines other", data[c]);
      end
   endtask

   task automatic t_lines_single;
      mode = 1'b1; code = '0;
      for (int i = 0; i < N; i++) begin
         lines = N'(1) << i;
         data  = N'(1) << i;   check("R4 chosen high", 1'b1);
         data  = ~(N'(1) << i); check("R4 chosen low", 1'b0);
      end
   endtask

   task automatic t_lines_all_patterns;
      logic [N-1:0] pats [4] = '{8'b0101_1010, 8'b1111_0000, 8'b0000_1111, 8'b1001_0011};
      mode = 1'b1; code = '0;
      for (int p = 0; p < 4; p++) begin
         for (int l = 0; l < (1 << N); l++) begin
            lines = N'(l); data = pats[p];
            check((l == 0) ? "R6 zero lines" : "R5", lowest(lines, data));
         end
      end
   endtask

   task automatic t_lines_ignore_code;
      mode = 1'b1; lines = 8'b0011_0000; data = 8'b0010_0000;
      for (int c = 0; c < N; c++) begin
         code = CW'(c);
         check("R7 code ignored", 1'b0);
      end
      lines = 8'b0000_0000;
      for (int c = 0; c < N; c++) begin
         code = CW'(c); data = '1;
         check("R7 code ignored idle", 1'b0);
      end
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      mode = 1'b0; data = '0; code = '0; lines = '0;
      repeat (2) @(posedge clk);
      t_idle();
      t_code_exhaustive();
      t_code_critical();
      t_code_ignores_lines();
      t_lines_single();
      t_lines_all_patterns();
      t_lines_ignore_code();
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run hung, got no completion expected completion");
         summary();
         $finish;
      end
   end

endmodule